// File: doc/BRIEF.md
# Framebuffer Controller Register Bank with Frame Interrupt

This block is the control and status part of a simple framebuffer controller. It decodes a byte-addressed register window of 32 bytes, of which it owns the upper sixteen offsets (0x10 to 0x1F). The lower sixteen offsets belong to other logic, such as the palette. The bank holds three kinds of register:

- a control byte whose top bit enables the frame interrupt;
- a status byte that combines a live interrupt-pending flag with fixed board-identification bits;
- fourteen general storage bytes used by software for cursor and video-control settings.

The display timing logic gives the bank a one-cycle frame-end pulse. When the interrupt is enabled, that pulse latches a pending event, and the event drives a level interrupt output. Software acknowledges the event by writing anything to the status byte.

One request is accepted per cycle. It carries a start offset, a write flag, a size code and up to four data bytes. Byte lane i covers offset start+i and uses data bits [8i+7:8i]. Read data is registered.

Top module: `fbc_regbank`

## Requirements
- R1: After a cycle with `rst_n` low, `irq` is 0, the control byte and all general storage bytes read 0, and the status byte reads 0x61.
- R2: Offset 0x10 is the control byte, readable and writable as a full byte. Its bit 7 enables the frame interrupt.
- R3: A read of offset 0x11 returns bit 7 equal to the pending flag, bits 6:5 set and bit 0 set. Bits 4:1 are 0.
- R4: When `frame_end` is high at a clock edge and control bit 7 is set, the pending flag and `irq` are 1 after that edge. When control bit 7 is clear, `frame_end` has no effect on `irq`.
- R5: A write that touches offset 0x11 clears the pending flag, so `irq` is 0 after that edge. The data written is ignored.
- R6: If an enabled `frame_end` and a status write happen at the same edge, the frame event wins and `irq` stays 1.
- R7: Offsets 0x12 to 0x1F are plain byte registers that read back the last value written. Offsets 0x12, 0x13 and 0x14 are used for cursor start, cursor end and video control.
- R8: `req_size` is the byte count minus one (0 to 3). Lane i addresses offset `req_addr`+i and uses data bits [8i+7:8i]. Lanes at or above the byte count are inactive and read 0.
- R9: Offsets 0x00 to 0x0F read 0 and ignore writes. Lanes whose offset would pass 0x1F are dropped: they read 0 and write nothing.
- R10: Read data appears on `rd_data` one clock edge after a read request. It holds its value until the next read request.
- R11: Once set, the pending flag and `irq` stay 1 until a status write, even if control bit 7 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Start byte offset in the 32-byte window |
| req_size | input | 2 | Byte count minus one |
| req_wdata | input | 32 | Write data, lane i in bits [8i+7:8i] |
| rd_data | output | 32 | Registered read data, lane i in bits [8i+7:8i] |
| frame_end | input | 1 | One-cycle end-of-frame pulse from display timing |
| irq | output | 1 | Level frame interrupt |

## Verification
The hardest case to reach from the ports is an enabled frame-end pulse landing in the same cycle as a status write. Only that case shows which of the two wins. The bench first enables the interrupt and raises one event. It then drives the pulse and a status write together in one cycle, and checks that `irq` stays high. A later write on its own must then clear it. Multi-byte writes are also aimed so that their upper lanes spill past the end of the window, or their lower lanes fall below the bank, to prove that those lanes are dropped.

// File: rtl/fbc_pkg.sv
// Package fbc_pkg
// Shared constants for the framebuffer register bank: bank-relative indices
// of the special bytes, bit positions and the fixed identification pattern.
// Assumes the bank occupies the top half of the register window.
package fbc_pkg;
    localparam int CTRL_IDX     = 0;      // bank index of control byte (offset 0x10)
    localparam int STAT_IDX     = 1;      // bank index of status byte (offset 0x11)
    localparam int IE_BIT       = 7;      // interrupt enable in control byte
    localparam int PEND_BIT     = 7;      // pending flag in status byte
    localparam logic [7:0] STAT_ID = 8'h61; // monitor id 0x60 | colour board 0x01
endpackage

// File: rtl/fbc_lane_decode.sv
// Module fbc_lane_decode
// Decodes one byte lane of a bus request: works out the lane's offset,
// whether the lane is active for the given size and whether it falls
// inside the register bank. Assumes the bank is the highest 2**BANK_W
// offsets of a 2**ADDR_W window; offsets that overflow the window are dropped.
module fbc_lane_decode #(
    parameter int ADDR_W = 5,
    parameter int BANK_W = 4,
    parameter int SIZE_W = 2,
    parameter int LANE   = 0
) (
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    output logic              lane_hit,
    output logic [BANK_W-1:0] lane_idx
);
    localparam int SUM_W = ADDR_W + 1;

    logic [SUM_W-1:0] lane_off;
    logic             lane_on;
    logic             in_bank;

    // Purpose: compute lane offset, activity and bank membership.
    always_comb begin
        lane_off = {1'b0, req_addr} + SUM_W'(LANE);
        lane_on  = req_valid && (32'(req_size) >= LANE);
        in_bank  = !lane_off[ADDR_W] && (&lane_off[ADDR_W-1:BANK_W]);
        lane_hit = lane_on && in_bank;
        lane_idx = lane_off[BANK_W-1:0];
    end
endmodule

// File: rtl/fbc_irq_ctrl.sv
// Module fbc_irq_ctrl
// Holds the frame-interrupt pending flag. An enabled frame-end pulse sets
// it and a status acknowledge clears it; when both occur together the
// new event wins. The flag is the interrupt level.
module fbc_irq_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic irq_en,
    input  logic stat_ack,
    output logic pending
);
    // Purpose: set on enabled frame end, clear on acknowledge, reset low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (frame_end && irq_en) begin
            pending <= 1'b1;
        end else if (stat_ack) begin
            pending <= 1'b0;
        end
    end
endmodule

// File: rtl/fbc_reg_store.sv
// Module fbc_reg_store
// Byte storage for the register bank. Each bank index except the status
// byte is a plain byte register written by whichever active lane addresses
// it. Distinct lanes of one request always address distinct indices.
// The status index stores nothing and reads 0 here.
module fbc_reg_store #(
    parameter int BANK_W    = 4,
    parameter int BUS_BYTES = 4
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [BUS_BYTES-1:0]                lane_hit,
    input  logic [BUS_BYTES-1:0][BANK_W-1:0]    lane_idx,
    input  logic [BUS_BYTES-1:0][7:0]           lane_wdata,
    output logic [(2**BANK_W)-1:0][7:0]         regs
);
    import fbc_pkg::*;
    localparam int DEPTH = 2 ** BANK_W;

    for (genvar k = 0; k < DEPTH; k++) begin : g_entry
        if (k == STAT_IDX) begin : g_stat
            assign regs[k] = 8'h00;
        end else begin : g_byte
            logic       we;
            logic [7:0] wd;

            // Purpose: find the lane, if any, that writes this entry.
            always_comb begin
                we = 1'b0;
                wd = 8'h00;
                for (int l = 0; l < BUS_BYTES; l++) begin
                    if (wr_en && lane_hit[l] && (32'(lane_idx[l]) == k)) begin
                        we = 1'b1;
                        wd = lane_wdata[l];
                    end
                end
            end

            // Purpose: hold the byte, clear on reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    regs[k] <= 8'h00;
                end else if (we) begin
                    regs[k] <= wd;
                end
            end
        end
    end
endmodule

// File: rtl/fbc_regbank.sv
// Module fbc_regbank
// Top of the framebuffer control/status register bank. Decodes up to
// BUS_BYTES lanes per request, writes the byte store, turns status writes
// into interrupt acknowledges, merges the live pending flag with fixed
// identification bits on reads and registers the read data.
// Assumes one request per cycle and a one-cycle frame_end pulse.
module fbc_regbank #(
    parameter int ADDR_W    = 5,
    parameter int BANK_W    = 4,
    parameter int BUS_BYTES = 4,
    parameter int SIZE_W    = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [SIZE_W-1:0]      req_size,
    input  logic [BUS_BYTES*8-1:0] req_wdata,
    output logic [BUS_BYTES*8-1:0] rd_data,
    input  logic                   frame_end,
    output logic                   irq
);
    import fbc_pkg::*;
    localparam int DEPTH = 2 ** BANK_W;

    logic [BUS_BYTES-1:0]             lane_hit;
    logic [BUS_BYTES-1:0][BANK_W-1:0] lane_idx;
    logic [BUS_BYTES-1:0][7:0]        lane_wdata;
    logic [BUS_BYTES-1:0][7:0]        lane_rdata;
    logic [DEPTH-1:0][7:0]            regs;
    logic                             wr_fire;
    logic                             rd_fire;
    logic                             stat_ack;
    logic                             ctrl_en;
    logic                             pending;
    logic [7:0]                       stat_byte;

    assign wr_fire    = req_valid && req_write;
    assign rd_fire    = req_valid && !req_write;
    assign lane_wdata = req_wdata;
    assign ctrl_en    = regs[CTRL_IDX][IE_BIT];

    for (genvar l = 0; l < BUS_BYTES; l++) begin : g_lane
        fbc_lane_decode #(
            .ADDR_W (ADDR_W),
            .BANK_W (BANK_W),
            .SIZE_W (SIZE_W),
            .LANE   (l)
        ) u_dec (
            .req_valid (req_valid),
            .req_addr  (req_addr),
            .req_size  (req_size),
            .lane_hit  (lane_hit[l]),
            .lane_idx  (lane_idx[l])
        );
    end

    fbc_reg_store #(
        .BANK_W    (BANK_W),
        .BUS_BYTES (BUS_BYTES)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_fire),
        .lane_hit   (lane_hit),
        .lane_idx   (lane_idx),
        .lane_wdata (lane_wdata),
        .regs       (regs)
    );

    // Purpose: flag a write that touches the status byte as an acknowledge.
    always_comb begin
        stat_ack = 1'b0;
        for (int l = 0; l < BUS_BYTES; l++) begin
            if (wr_fire && lane_hit[l] && (32'(lane_idx[l]) == STAT_IDX)) begin
                stat_ack = 1'b1;
            end
        end
    end

    fbc_irq_ctrl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_end (frame_end),
        .irq_en    (ctrl_en),
        .stat_ack  (stat_ack),
        .pending   (pending)
    );

    assign irq = pending;

    // Purpose: build the status byte from the live flag and fixed id bits.
    always_comb begin
        stat_byte = STAT_ID;
        stat_byte[PEND_BIT] = pending;
    end

    // Purpose: per-lane read mux, zero for inactive or out-of-bank lanes.
    always_comb begin
        for (int l = 0; l < BUS_BYTES; l++) begin
            if (!lane_hit[l]) begin
                lane_rdata[l] = 8'h00;
            end else if (32'(lane_idx[l]) == STAT_IDX) begin
                lane_rdata[l] = stat_byte | regs[lane_idx[l]];
            end else begin
                lane_rdata[l] = regs[lane_idx[l]];
            end
        end
    end

    // Purpose: register read data on a read request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_fire) begin
            rd_data <= lane_rdata;
        end
    end
endmodule

// File: rtl/fbc_regbank_chk.sv
// Module fbc_regbank_chk
// Assertion checker bound to fbc_regbank. It watches the interrupt
// handshake and the read-data hold rule.
module fbc_regbank_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          frame_end,
    input logic          ctrl_en,
    input logic          stat_ack,
    input logic          irq,
    input logic          rd_fire,
    input logic [DW-1:0] rd_data
);
    // R1
    reset_irq_low_chk: assert property (@(posedge clk) !rst_n |=> !irq);

    // R4
    frame_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_end && ctrl_en) |=> irq);

    // R4
    irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(frame_end && ctrl_en));

    // R5
    ack_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ack && !(frame_end && ctrl_en)) |=> !irq);

    // R6
    event_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_ack && frame_end && ctrl_en) |=> irq);

    // R11
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_ack) |=> irq);

    // R10
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_fire |=> $stable(rd_data));
endmodule

bind fbc_regbank fbc_regbank_chk #(.DW(BUS_BYTES * 8)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_end (frame_end),
    .ctrl_en   (ctrl_en),
    .stat_ack  (stat_ack),
    .irq       (irq),
    .rd_fire   (rd_fire),
    .rd_data   (rd_data)
);

// File: tb/fbc_regbank_test.sv
// Scoreboard bench for fbc_regbank: the read driver pushes expected words,
// and a monitor pops and compares them one edge later.
module fbc_regbank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [4:0]  req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rd_data;
    logic        frame_end = 1'b0;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    fbc_regbank uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rd_data(rd_data), .frame_end(frame_end), .irq(irq)
    );

    // monitor: a read accepted at this edge is compared just after it
    always @(posedge clk) begin
        if (rst_n && req_valid && !req_write) begin
            exp_t it;
            it = sb.pop_front();
            #1;
            checks++;
            if (rd_data !== it.exp) begin
                fails++;
                $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.exp);
            end
        end
    end

    task automatic bus_write(input logic [4:0] a, input logic [1:0] s, input logic [31:0] d,
                             input logic ev);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_size = s; req_wdata = d;
        frame_end = ev;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; frame_end = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, input logic [1:0] s, input logic [31:0] e,
                            input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = s;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string tag);
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s irq actual=%b expected=%b", tag, irq, e);
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_irq(1'b0, "R1 reset");
        // R1 R3 R8: ctrl 0, status 0x61, cursor bytes 0
        bus_read(5'h10, 2'd3, 32'h0000_6100, "R1 R3 R8 reset read");
        // R4 disabled: no interrupt
        pulse_frame();
        check_irq(1'b0, "R4 disabled frame");
        // R2 enable
        bus_write(5'h10, 2'd0, 32'h0000_0080, 1'b0);
        bus_read(5'h10, 2'd0, 32'h0000_0080, "R2 ctrl readback");
        pulse_frame();
        check_irq(1'b1, "R4 enabled frame");
        bus_read(5'h11, 2'd0, 32'h0000_00E1, "R3 status pending");
        // R11: disable keeps pending
        bus_write(5'h10, 2'd0, 32'h0, 1'b0);
        check_irq(1'b1, "R11 sticky after disable");
        // R5 ack with zero data
        bus_write(5'h11, 2'd0, 32'h0, 1'b0);
        check_irq(1'b0, "R5 ack");
        bus_read(5'h11, 2'd0, 32'h0000_0061, "R5 R3 status cleared");
        // R6 collision
        bus_write(5'h10, 2'd0, 32'h0000_0080, 1'b0);
        pulse_frame();
        check_irq(1'b1, "R6 setup");
        bus_write(5'h11, 2'd0, 32'h0000_00FF, 1'b1);
        check_irq(1'b1, "R6 event beats ack");
        bus_write(5'h11, 2'd0, 32'h0000_00FF, 1'b0);
        check_irq(1'b0, "R5 ack with ones");
        // R7 R8 storage and lanes
        bus_write(5'h12, 2'd3, 32'hDDCC_BBAA, 1'b0);
        bus_read(5'h12, 2'd3, 32'hDDCC_BBAA, "R7 R8 four-byte");
        // R10 hold
        bus_write(5'h16, 2'd1, 32'hFFFF_1234, 1'b0);
        repeat (2) @(negedge clk);
        checks++;
        if (rd_data !== 32'hDDCC_BBAA) begin
            fails++;
            $display("FAIL R10 hold rd_data actual=%h expected=%h", rd_data, 32'hDDCC_BBAA);
        end
        bus_read(5'h16, 2'd1, 32'h0000_1234, "R8 two-byte upper lanes zero");
        bus_read(5'h13, 2'd0, 32'h0000_00BB, "R7 cursor end byte");
        // R9 window end
        bus_write(5'h1F, 2'd3, 32'h1122_3344, 1'b0);
        bus_read(5'h1F, 2'd3, 32'h0000_0044, "R9 lanes past end");
        bus_read(5'h1E, 2'd3, 32'h0000_4400, "R9 R7 last bytes");
        // R9 lower half
        bus_write(5'h08, 2'd3, 32'hFFFF_FFFF, 1'b0);
        bus_write(5'h0E, 2'd1, 32'hFFFF_FFFF, 1'b0);
        bus_read(5'h08, 2'd3, 32'h0000_0000, "R9 unmapped read");
        check_irq(1'b0, "R9 no side effect");
        bus_read(5'h0E, 2'd3, 32'h6180_0000, "R9 straddle bank edge");
        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule